// File: doc/BRIEF.md
# Triggered Quadrature Position Capture

This block turns the A/B pulse pair of an incremental position encoder into a signed position count. It synchronises both lines and decodes every edge of either line, so one full quadrature cycle moves the count by four. A synchronous command forces the count to zero, which lets software treat later readings as absolute positions.

The count is not streamed out continuously. A readout trigger from the timing receiver causes a snapshot record to be written into an internal FIFO. The record holds the position, the 64-bit timestamp present on the timing bus in the trigger cycle, a running frame number, the synchronised alarm line of the encoder interface, and a sticky flag for illegal encoder transitions. Downstream logic pops records through a show-ahead read port. A clear command at run boundaries empties the FIFO and restarts the frame numbering. When the FIFO is full, a trigger drops its record but still advances the frame number, so a gap is visible downstream.

Top module: `quad_capture`

## Requirements
- R1: With the encoder state written {A,B}, each step of the sequence 00→10→11→01→00 (A leading) adds 1 to the position, and each step of the reverse sequence subtracts 1.
- R2: Encoder state changes spaced two clock cycles apart are all counted. A change shows in the position no later than three cycles after it reaches the pins.
- R3: A transition where A and B change together leaves the position unchanged and sets a sticky error bit. The bit is carried in every later record (out_err) until a clear.
- R4: zero_cmd sets the position to 0 on the next edge and wins over any count in that cycle. A record triggered in the same cycle holds the value from before the zero.
- R5: A cycle with trig high and clear_cmd low stores a record of the current position, the ts_in value of that cycle, the frame number, the alarm and the error bit. The record is readable from the next cycle.
- R6: The frame number starts at 0 after reset or clear and goes up by one for every trigger that is not cancelled by a clear.
- R7: A trigger that finds the FIFO full (DEPTH records) stores nothing, sets the sticky overflow output and still advances the frame number.
- R8: clear_cmd empties the FIFO and clears overflow, the error bit and the frame number. A trigger in the same cycle is discarded.
- R9: The alarm input passes through a two-flop synchroniser, and its state is stored in each record (out_alarm).
- R10: Records leave in trigger order. The head is shown while out_valid is high, and rd_en pops it.
- R11: After reset, out_valid and overflow are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enc_a | input | 1 | Encoder channel A, asynchronous |
| enc_b | input | 1 | Encoder channel B, asynchronous |
| enc_alarm | input | 1 | Combined alarm line from the encoder interface, asynchronous |
| trig | input | 1 | Readout trigger, one record per high cycle |
| ts_in | input | 64 | Timestamp bus from the timing system |
| zero_cmd | input | 1 | Force the position to zero |
| clear_cmd | input | 1 | Flush the FIFO and restart frame numbering |
| rd_en | input | 1 | Pop the head record |
| out_valid | output | 1 | A record is present at the head |
| out_pos | output | 32 | Captured signed position |
| out_ts | output | 64 | Captured timestamp |
| out_frame | output | 16 | Captured frame number |
| out_alarm | output | 1 | Captured alarm state |
| out_err | output | 1 | Captured sticky transition error |
| overflow | output | 1 | Sticky: a record was dropped on a full FIFO |

## Verification
The bench targets count direction across the zero crossing into negative values and fast bursts at the two-cycle spacing limit. A decoder with the sense of direction swapped, or one that misses edges, gives wrong signed positions. It also tests a zero coinciding with a trigger: a design that lets the zero win over the capture would record 0 instead of the previous position. It fills the FIFO past its depth: a design that stops the frame number on drops would hide the lost records. Finally it issues a clear together with a trigger: a design that stores that record, or does not restart frames at 0, breaks the gap detection downstream.

// File: rtl/quad_capture.sv
module quad_capture #(
  parameter int POS_W   = 32,
  parameter int TS_W    = 64,
  parameter int FRAME_W = 16,
  parameter int DEPTH   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enc_a,
  input  logic               enc_b,
  input  logic               enc_alarm,
  input  logic               trig,
  input  logic [TS_W-1:0]    ts_in,
  input  logic               zero_cmd,
  input  logic               clear_cmd,
  input  logic               rd_en,
  output logic               out_valid,
  output logic [POS_W-1:0]   out_pos,
  output logic [TS_W-1:0]    out_ts,
  output logic [FRAME_W-1:0] out_frame,
  output logic               out_alarm,
  output logic               out_err,
  output logic               overflow
);
  localparam int AW    = $clog2(DEPTH);
  localparam int REC_W = POS_W + TS_W + FRAME_W + 2;

  logic [1:0] a_sync, b_sync, alm_sync, prev;
  logic [1:0] cur;
  logic       step_up, step_dn, illegal;
  logic signed [POS_W-1:0] pos_q;
  logic [FRAME_W-1:0] frame_q;
  logic       err_q;

  logic [REC_W-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr, rptr;
  logic [AW:0]      cnt;
  logic             full, wr, rd;
  logic [REC_W-1:0] rec;

  assign cur = {a_sync[1], b_sync[1]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      a_sync   <= '0;
      b_sync   <= '0;
      alm_sync <= '0;
      prev     <= '0;
    end else begin
      a_sync   <= {a_sync[0], enc_a};
      b_sync   <= {b_sync[0], enc_b};
      alm_sync <= {alm_sync[0], enc_alarm};
      prev     <= cur;
    end

  always_comb begin
    step_up = (prev == 2'b00 && cur == 2'b10) || (prev == 2'b10 && cur == 2'b11) ||
              (prev == 2'b11 && cur == 2'b01) || (prev == 2'b01 && cur == 2'b00);
    step_dn = (prev == 2'b10 && cur == 2'b00) || (prev == 2'b11 && cur == 2'b10) ||
              (prev == 2'b01 && cur == 2'b11) || (prev == 2'b00 && cur == 2'b01);
    illegal = (prev ^ cur) == 2'b11;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        pos_q <= '0;
    else if (zero_cmd) pos_q <= '0;
    else if (step_up)  pos_q <= pos_q + 1'b1;
    else if (step_dn)  pos_q <= pos_q - 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      err_q    <= 1'b0;
      frame_q  <= '0;
      overflow <= 1'b0;
    end else if (clear_cmd) begin
      err_q    <= 1'b0;
      frame_q  <= '0;
      overflow <= 1'b0;
    end else begin
      if (illegal) err_q <= 1'b1;
      if (trig) begin
        frame_q <= frame_q + 1'b1;
        if (full) overflow <= 1'b1;
      end
    end

  assign full      = cnt == (AW+1)'(DEPTH);
  assign out_valid = cnt != '0;
  assign wr        = trig && !clear_cmd && !full;
  assign rd        = rd_en && !clear_cmd && out_valid;

  always_ff @(posedge clk)
    if (wr) mem[wptr] <= {err_q, alm_sync[1], frame_q, ts_in, pos_q};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else if (clear_cmd) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (wr) wptr <= wptr + 1'b1;
      if (rd) rptr <= rptr + 1'b1;
      if (wr && !rd)      cnt <= cnt + 1'b1;
      else if (rd && !wr) cnt <= cnt - 1'b1;
    end

  assign rec       = mem[rptr];
  assign out_pos   = rec[POS_W-1:0];
  assign out_ts    = rec[POS_W +: TS_W];
  assign out_frame = rec[POS_W+TS_W +: FRAME_W];
  assign out_alarm = rec[REC_W-2];
  assign out_err   = rec[REC_W-1];
endmodule

// File: rtl/quad_capture_chk.sv
module quad_capture_chk #(
  parameter int POS_W = 32
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    zero_cmd,
  input logic                    trig,
  input logic                    clear_cmd,
  input logic                    rd_en,
  input logic                    out_valid,
  input logic                    overflow,
  input logic signed [POS_W-1:0] pos
);
  a_r4_zero_forces_pos: assert property (@(posedge clk) disable iff (!rst_n)
    zero_cmd |=> pos == '0);

  a_r1_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    !zero_cmd |=> (pos == $past(pos)) || (pos == $past(pos) + 1) || (pos == $past(pos) - 1));

  a_r8_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clear_cmd |=> !out_valid && !overflow);

  a_r5_trig_makes_valid: assert property (@(posedge clk) disable iff (!rst_n)
    trig && !clear_cmd |=> out_valid);

  a_r7_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow && !clear_cmd |=> overflow);

  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !trig && !rd_en && !clear_cmd |=> out_valid == $past(out_valid));
endmodule

bind quad_capture quad_capture_chk #(.POS_W(POS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .zero_cmd(zero_cmd), .trig(trig), .clear_cmd(clear_cmd),
  .rd_en(rd_en), .out_valid(out_valid), .overflow(overflow), .pos(pos_q)
);

// File: tb/test_quad_capture.sv
`timescale 1ns/1ps
module test_quad_capture;
  localparam int DEPTH = 16;

  logic clk = 0, rst_n = 0;
  logic enc_a = 0, enc_b = 0, enc_alarm = 0, trig = 0, zero_cmd = 0, clear_cmd = 0, rd_en = 0;
  logic [63:0] ts_in = '0;
  logic out_valid, out_alarm, out_err, overflow;
  logic [31:0] out_pos;
  logic [63:0] out_ts;
  logic [15:0] out_frame;

  always #2.5 clk = ~clk;

  quad_capture #(.DEPTH(DEPTH)) i_quad_capture (
    .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b), .enc_alarm(enc_alarm),
    .trig(trig), .ts_in(ts_in), .zero_cmd(zero_cmd), .clear_cmd(clear_cmd), .rd_en(rd_en),
    .out_valid(out_valid), .out_pos(out_pos), .out_ts(out_ts), .out_frame(out_frame),
    .out_alarm(out_alarm), .out_err(out_err), .overflow(overflow)
  );

  typedef struct {
    logic [31:0] pos;
    logic [63:0] ts;
    logic [15:0] frame;
    logic        alarm;
    logic        err;
    string       tag;
  } rec_t;

  rec_t q[$];
  int checks = 0, failures = 0;
  bit drain = 1, done = 0;
  logic [1:0] st = 2'b00;
  int model_pos = 0;
  logic [15:0] model_frame = 0;
  logic model_err = 0;
  logic [63:0] ts_seed = 64'h1234_5678_0000_0000;

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    rd_en <= 1'b0;
    if (rst_n && drain && out_valid) begin
      if (q.size() == 0) begin
        check(0, "R10", "unexpected record frame", longint'(out_frame), -1);
      end else begin
        rec_t e;
        e = q.pop_front();
        check(out_pos == e.pos, e.tag, "pos", longint'($signed(out_pos)), longint'($signed(e.pos)));
        check(out_ts == e.ts, e.tag, "ts", longint'(out_ts), longint'(e.ts));
        check(out_frame == e.frame, e.tag, "frame", longint'(out_frame), longint'(e.frame));
        check(out_alarm == e.alarm && out_err == e.err, e.tag, "alarm/err",
              longint'({out_alarm, out_err}), longint'({e.alarm, e.err}));
      end
      rd_en <= 1'b1;
    end
  end

  function automatic logic [1:0] nxt(logic [1:0] s, bit up);
    case (s)
      2'b00: return up ? 2'b10 : 2'b01;
      2'b10: return up ? 2'b11 : 2'b00;
      2'b11: return up ? 2'b01 : 2'b10;
      default: return up ? 2'b00 : 2'b11;
    endcase
  endfunction

  task automatic steps(int n, bit up, int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      st = nxt(st, up);
      {enc_a, enc_b} = st;
      model_pos += up ? 1 : -1;
      repeat (gap - 1) @(negedge clk);
    end
    repeat (5) @(negedge clk);
  endtask

  task automatic fire(string tag, bit store, bit with_zero);
    rec_t e;
    @(negedge clk);
    ts_seed = ts_seed + 64'h0000_0001_0000_0003;
    ts_in = ts_seed;
    trig = 1;
    zero_cmd = with_zero;
    e.pos = 32'(model_pos); e.ts = ts_seed; e.frame = model_frame;
    e.alarm = enc_alarm; e.err = model_err; e.tag = tag;
    if (store) q.push_back(e);
    model_frame++;
    if (with_zero) model_pos = 0;
    @(negedge clk);
    trig = 0;
    zero_cmd = 0;
  endtask

  task automatic wait_empty();
    for (int i = 0; i < 200 && (q.size() != 0 || out_valid); i++) @(negedge clk);
    check(q.size() == 0, "R10", "records left", q.size(), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(out_valid == 0, "R11", "out_valid after reset", out_valid, 0);
    check(overflow == 0, "R11", "overflow after reset", overflow, 0);

    steps(5, 1, 4);
    fire("R1 up", 1, 0);
    steps(8, 0, 4);
    fire("R1 down negative", 1, 0);
    steps(12, 1, 2);
    fire("R2 burst", 1, 0);
    steps(7, 0, 2);
    fire("R2 burst down", 1, 0);

    enc_alarm = 1;
    repeat (4) @(negedge clk);
    fire("R9 alarm set", 1, 0);
    enc_alarm = 0;
    repeat (4) @(negedge clk);
    fire("R9 alarm clear", 1, 0);

    fire("R4 zero with capture", 1, 1);
    fire("R4 after zero", 1, 0);
    steps(3, 1, 3);
    fire("R4 count after zero", 1, 0);

    @(negedge clk);
    st = st ^ 2'b11;
    {enc_a, enc_b} = st;
    model_err = 1;
    repeat (5) @(negedge clk);
    fire("R3 illegal jump", 1, 0);
    steps(2, 1, 3);
    fire("R3 sticky err", 1, 0);
    wait_empty();

    drain = 0;
    @(negedge clk);
    fire("R8 flushed", 0, 0);
    fire("R8 flushed", 0, 0);
    check(out_valid == 1, "R5", "valid before clear", out_valid, 1);
    @(negedge clk);
    clear_cmd = 1;
    trig = 1;
    @(negedge clk);
    clear_cmd = 0;
    trig = 0;
    q.delete();
    model_frame = 0;
    model_err = 0;
    check(out_valid == 0, "R8", "valid after clear", out_valid, 0);
    check(overflow == 0, "R8", "overflow after clear", overflow, 0);
    drain = 1;
    fire("R8 frame restart", 1, 0);
    fire("R6 frame next", 1, 0);
    wait_empty();

    drain = 0;
    @(negedge clk);
    for (int i = 0; i < DEPTH + 2; i++) begin
      fire("R7 fill", i < DEPTH, 0);
      if (i == DEPTH - 1)
        check(overflow == 0, "R7", "overflow at exactly full", overflow, 0);
    end
    check(overflow == 1, "R7", "overflow after drop", overflow, 1);
    drain = 1;
    wait_empty();
    fire("R7 frame after drops", 1, 0);
    wait_empty();
    check(overflow == 1, "R7", "overflow sticky", overflow, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule